// File: doc/BRIEF.md
# Trace Enable Control Register with Write Fault Checking

This block holds the eight-bit control word that turns instruction tracing on and off for one logical processor. Software reaches it through a single-cycle write strobe and a read bus that always shows the current value. Every write is screened before it is accepted. It is refused when it sets bits that do not exist. It is also refused when it sets a field whose hardware capability input is low. A third refusal case is a change to any field other than the master enable while tracing is running. A refused write leaves the register as it was and raises a one-cycle fault pulse.

Three events act on the register apart from writes. A cold reset zeroes it. A warm reset either drops only the master enable or zeroes the whole word, depending on a capability input. A system-management interrupt drops only the master enable. Whenever the master enable falls through a write, a warm reset or an interrupt, the block pulses a flush request for one cycle. A packet-generation enable output is derived from the master enable and the allow bit that matches the current privilege level.

Top module: `trc_ctl_top`

## Requirements
- R1: A cold reset (synchronous, active high) forces rd_data, wr_fault, flush_req and gen_en to 0. It does not pulse flush_req even when the master enable was 1.
- R2: Bit layout: bit 0 master enable, bit 1 cycle-count packets, bit 2 allow at privilege 0, bit 3 allow at privilege above 0, bit 4 power-event packets, bit 5 follow-write-with-IP packets, bit 6 transport output select, bit 7 address-space filter. An accepted write stores wr_data[7:0], which is visible on rd_data after the write edge. rd_data[31:8] always reads 0.
- R3: A write with any of wr_data[31:8] set is refused. The register keeps its value, and wr_fault is 1 for exactly the cycle after the write edge.
- R4: Writing 1 to bit 1 while cap_cyc is 0, or to bit 6 while cap_xport is 0, is refused and faults as in R3.
- R5: While bit 0 is 1, a write that differs from the current value in any of bits 7:1 is refused and faults. A write equal to the current value, or one that differs only by clearing bit 0, is accepted without a fault.
- R6: A warm reset with cap_keep_warm at 1 clears bit 0 only and keeps bits 7:1. With cap_keep_warm at 0 it clears the whole register.
- R7: An interrupt event (sm_int) clears bit 0 and leaves bits 7:1 unchanged.
- R8: When bit 0 falls from 1 to 0 by write, warm reset or interrupt, flush_req is 1 for exactly one cycle, the cycle after that edge.
- R9: gen_en is 1 only when bit 0 is 1 and the allow bit for cur_priv is 1 (bit 2 when cur_priv is 0, bit 3 otherwise).
- R10: When events coincide, cold reset wins over warm reset, warm reset over the interrupt, and the interrupt over a write. A write that loses to an event is dropped and raises no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous cold reset, active high |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| sm_int | input | 1 | System-management interrupt event, one cycle |
| cap_cyc | input | 1 | Cycle-count packet capability present |
| cap_xport | input | 1 | Transport output capability present |
| cap_keep_warm | input | 1 | Keep configuration across warm reset |
| cur_priv | input | 2 | Current privilege level |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value, upper bits zero |
| wr_fault | output | 1 | One-cycle pulse for a refused write |
| gen_en | output | 1 | Packet generation enable |
| flush_req | output | 1 | One-cycle flush request on disable |

## Verification
The hardest case to reach is a write that coincides with one or more events. The write must vanish without a fault, and the register must show only the winning event's effect. The stimulus first loads a known non-zero value with tracing on. It then drives the interrupt, warm reset and cold reset strobes in the same cycle as a write that would otherwise be accepted or refused. The cold reset case is entered with tracing on, which shows that no flush pulse follows it.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int CTL_W  = 8;
  localparam int B_EN   = 0;
  localparam int B_CYC  = 1;
  localparam int B_KERN = 2;
  localparam int B_USER = 3;
  localparam int B_PWR  = 4;
  localparam int B_FOLW = 5;
  localparam int B_XPRT = 6;
  localparam int B_ASF  = 7;

  typedef logic [CTL_W-1:0] ctl_t;

  // Bits software may set, given the capability inputs
  function automatic ctl_t writable_mask(input logic cyc_ok, input logic xprt_ok);
    ctl_t m;
    m = '1;
    m[B_CYC]  = cyc_ok;
    m[B_XPRT] = xprt_ok;
    return m;
  endfunction

  // While enabled only the enable bit may change
  function automatic logic locked_change(input ctl_t cur, input ctl_t nxt);
    ctl_t keep;
    keep = '1;
    keep[B_EN] = 1'b0;
    return cur[B_EN] && ((cur & keep) != (nxt & keep));
  endfunction

  // Warm reset result
  function automatic ctl_t warm_value(input ctl_t cur, input logic keep_cfg);
    ctl_t r;
    r = keep_cfg ? cur : '0;
    r[B_EN] = 1'b0;
    return r;
  endfunction

  // Allow bit for the current privilege level
  function automatic logic priv_allows(input ctl_t cur, input logic [1:0] priv);
    return (priv == 2'd0) ? cur[B_KERN] : cur[B_USER];
  endfunction
endpackage

// File: rtl/trc_wr_check.sv
module trc_wr_check
  import trc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] wr_data,
  input  ctl_t              ctl_q,
  input  logic              cap_cyc,
  input  logic              cap_xport,
  output logic              hi_resv,
  output logic              cap_resv,
  output logic              lock_viol,
  output logic              illegal
);
  generate
    if (DATA_W > CTL_W) begin : g_hi
      assign hi_resv = |wr_data[DATA_W-1:CTL_W];
    end else begin : g_nohi
      assign hi_resv = 1'b0;
    end
  endgenerate

  assign cap_resv  = |(wr_data[CTL_W-1:0] & ~writable_mask(cap_cyc, cap_xport));
  assign lock_viol = locked_change(ctl_q, wr_data[CTL_W-1:0]);
  assign illegal   = hi_resv | cap_resv | lock_viol;
endmodule

// File: rtl/trc_ctl_reg.sv
module trc_ctl_reg
  import trc_pkg::*;
(
  input  logic clk,
  input  logic cold_rst,
  input  logic warm_rst,
  input  logic sm_int,
  input  logic keep_warm,
  input  logic wr_en,
  input  ctl_t wr_val,
  input  logic wr_illegal,
  output ctl_t ctl_q,
  output logic wr_fault,
  output logic flush_req
);
  ctl_t ctl_d;
  logic ev_block;
  logic wr_take;
  logic wr_reject;
  logic en_fall;

  assign ev_block  = warm_rst | sm_int;
  assign wr_take   = wr_en & ~ev_block & ~wr_illegal;
  assign wr_reject = wr_en & ~ev_block & wr_illegal;

  always_comb begin
    ctl_d = ctl_q;
    if (warm_rst)     ctl_d = warm_value(ctl_q, keep_warm);
    else if (sm_int)  ctl_d = warm_value(ctl_q, 1'b1);
    else if (wr_take) ctl_d = wr_val;
  end

  assign en_fall = ctl_q[B_EN] & ~ctl_d[B_EN];

  always_ff @(posedge clk) begin
    if (cold_rst) begin
      ctl_q     <= '0;
      wr_fault  <= 1'b0;
      flush_req <= 1'b0;
    end else begin
      ctl_q     <= ctl_d;
      wr_fault  <= wr_reject;
      flush_req <= en_fall;
    end
  end

  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (cold_rst)
    wr_fault |-> ctl_q == $past(ctl_q)); // R3
  AST_LOCKED_FIELDS: assert property (@(posedge clk) disable iff (cold_rst)
    (ctl_q[B_EN] && !warm_rst && !sm_int) |=> ctl_q[CTL_W-1:1] == $past(ctl_q[CTL_W-1:1])); // R5
  AST_WARM_KEEP: assert property (@(posedge clk) disable iff (cold_rst)
    (warm_rst && keep_warm) |=> !ctl_q[B_EN] && ctl_q[CTL_W-1:1] == $past(ctl_q[CTL_W-1:1])); // R6
  AST_WARM_CLEAR: assert property (@(posedge clk) disable iff (cold_rst)
    (warm_rst && !keep_warm) |=> ctl_q == '0); // R6
  AST_SMI_CLEAR: assert property (@(posedge clk) disable iff (cold_rst)
    (sm_int && !warm_rst) |=> !ctl_q[B_EN] && ctl_q[CTL_W-1:1] == $past(ctl_q[CTL_W-1:1])); // R7
  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (cold_rst)
    flush_req |=> !flush_req); // R8
  AST_FLUSH_ON_FALL: assert property (@(posedge clk) disable iff (cold_rst)
    flush_req |-> !ctl_q[B_EN] && $past(ctl_q[B_EN])); // R8
  AST_EVENT_NO_FAULT: assert property (@(posedge clk) disable iff (cold_rst)
    (wr_en && (warm_rst || sm_int)) |=> !wr_fault); // R10
endmodule

// File: rtl/trc_priv_gate.sv
module trc_priv_gate
  import trc_pkg::*;
(
  input  ctl_t       ctl_q,
  input  logic [1:0] cur_priv,
  output logic       gen_en
);
  assign gen_en = ctl_q[B_EN] & priv_allows(ctl_q, cur_priv);
endmodule

// File: rtl/trc_ctl_top.sv
module trc_ctl_top
  import trc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              cold_rst,
  input  logic              warm_rst,
  input  logic              sm_int,
  input  logic              cap_cyc,
  input  logic              cap_xport,
  input  logic              cap_keep_warm,
  input  logic [1:0]        cur_priv,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_fault,
  output logic              gen_en,
  output logic              flush_req
);
  localparam int PAD_W = DATA_W - CTL_W;

  ctl_t ctl_q;
  logic hi_resv;
  logic cap_resv;
  logic lock_viol;
  logic wr_illegal;

  trc_wr_check #(.DATA_W(DATA_W)) u_check (
    .wr_data   (wr_data),
    .ctl_q     (ctl_q),
    .cap_cyc   (cap_cyc),
    .cap_xport (cap_xport),
    .hi_resv   (hi_resv),
    .cap_resv  (cap_resv),
    .lock_viol (lock_viol),
    .illegal   (wr_illegal)
  );

  trc_ctl_reg u_reg (
    .clk        (clk),
    .cold_rst   (cold_rst),
    .warm_rst   (warm_rst),
    .sm_int     (sm_int),
    .keep_warm  (cap_keep_warm),
    .wr_en      (wr_en),
    .wr_val     (wr_data[CTL_W-1:0]),
    .wr_illegal (wr_illegal),
    .ctl_q      (ctl_q),
    .wr_fault   (wr_fault),
    .flush_req  (flush_req)
  );

  trc_priv_gate u_gate (
    .ctl_q    (ctl_q),
    .cur_priv (cur_priv),
    .gen_en   (gen_en)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data = {{PAD_W{1'b0}}, ctl_q};
    end else begin : g_nopad
      assign rd_data = ctl_q;
    end
  endgenerate

  AST_RESERVED_FAULTS: assert property (@(posedge clk) disable iff (cold_rst)
    (wr_en && hi_resv && !warm_rst && !sm_int) |=> wr_fault); // R3
  AST_CAP_FAULTS: assert property (@(posedge clk) disable iff (cold_rst)
    (wr_en && cap_resv && !warm_rst && !sm_int) |=> wr_fault && rd_data == $past(rd_data)); // R4
  AST_LOCK_FAULTS: assert property (@(posedge clk) disable iff (cold_rst)
    (wr_en && lock_viol && !warm_rst && !sm_int) |=> wr_fault); // R5
  AST_GEN_NEEDS_EN: assert property (@(posedge clk) disable iff (cold_rst)
    gen_en |-> rd_data[B_EN]); // R9
endmodule

// File: tb/tb_trc_ctl_top.sv
module tb_trc_ctl_top;
  localparam int CLK_P = 10;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        cold_rst = 1'b1, warm_rst = 1'b0, sm_int = 1'b0;
  logic        cap_cyc = 1'b1, cap_xport = 1'b1, cap_keep_warm = 1'b1;
  logic [1:0]  cur_priv = 2'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        wr_fault, gen_en, flush_req;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  trc_ctl_top dut (
    .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst), .sm_int(sm_int),
    .cap_cyc(cap_cyc), .cap_xport(cap_xport), .cap_keep_warm(cap_keep_warm),
    .cur_priv(cur_priv), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wr_fault(wr_fault), .gen_en(gen_en), .flush_req(flush_req)
  );

  // {data[43:12], cyc[11], xport[10], fault[9], flush[8], rd[7:0]}
  localparam logic [43:0] VEC [NV] = '{
    {32'h0000_000C, 1'b1, 1'b1, 1'b0, 1'b0, 8'h0C}, // R2 plain write
    {32'h0000_0100, 1'b1, 1'b1, 1'b1, 1'b0, 8'h0C}, // R3 bit 8
    {32'h8000_0000, 1'b1, 1'b1, 1'b1, 1'b0, 8'h0C}, // R3 bit 31
    {32'h0000_0002, 1'b0, 1'b1, 1'b1, 1'b0, 8'h0C}, // R4 cycle cap off
    {32'h0000_0040, 1'b1, 1'b0, 1'b1, 1'b0, 8'h0C}, // R4 transport cap off
    {32'h0000_00F2, 1'b1, 1'b1, 1'b0, 1'b0, 8'hF2}, // R2 upper fields
    {32'h0000_000D, 1'b1, 1'b1, 1'b0, 1'b0, 8'h0D}, // R2 enable
    {32'h0000_000D, 1'b1, 1'b1, 1'b0, 1'b0, 8'h0D}, // R5 same value
    {32'h0000_000F, 1'b1, 1'b1, 1'b1, 1'b0, 8'h0D}, // R5 change locked
    {32'h0000_000C, 1'b1, 1'b1, 1'b0, 1'b1, 8'h0C}, // R5 R8 clear only enable
    {32'h0000_0001, 1'b1, 1'b1, 1'b0, 1'b0, 8'h01}, // R2 enable alone
    {32'h0000_0000, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00}  // R8 disable
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // One cycle of stimulus; returns at the next falling edge
  task automatic step(input logic we, input logic [31:0] d, input logic w,
                      input logic s, input logic c);
    wr_en = we; wr_data = d; warm_rst = w; sm_int = s; cold_rst = c;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; warm_rst = 1'b0; sm_int = 1'b0; cold_rst = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);
    step(1'b1, d, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b1);
    check("R1 rd_data after cold", rd_data, 32'h0);
    check("R1 wr_fault after cold", {31'h0, wr_fault}, 32'h0);
    check("R1 gen_en after cold", {31'h0, gen_en}, 32'h0);
    check("R1 flush_req after cold", {31'h0, flush_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      cap_cyc = VEC[i][11];
      cap_xport = VEC[i][10];
      wr(VEC[i][43:12]);
      check($sformatf("vector %0d fault (R3 R4 R5)", i), {31'h0, wr_fault}, {31'h0, VEC[i][9]});
      check($sformatf("vector %0d flush (R8)", i), {31'h0, flush_req}, {31'h0, VEC[i][8]});
      check($sformatf("vector %0d rd_data (R2)", i), rd_data, {24'h0, VEC[i][7:0]});
    end
    cap_cyc = 1'b1; cap_xport = 1'b1;

    // R9 privilege gating
    wr(32'h05);
    cur_priv = 2'd0; #1 check("R9 kernel allowed", {31'h0, gen_en}, 32'h1);
    cur_priv = 2'd3; #1 check("R9 priv 3 blocked", {31'h0, gen_en}, 32'h0);
    cur_priv = 2'd1; #1 check("R9 priv 1 blocked", {31'h0, gen_en}, 32'h0);
    wr(32'h04);
    check("R8 flush on write clear", {31'h0, flush_req}, 32'h1);
    wr(32'h09);
    cur_priv = 2'd0; #1 check("R9 kernel not allowed", {31'h0, gen_en}, 32'h0);
    cur_priv = 2'd2; #1 check("R9 user allowed", {31'h0, gen_en}, 32'h1);
    cur_priv = 2'd0;
    wr(32'h08);

    // R6 warm reset, keep and clear variants
    wr(32'h09);
    step(1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    check("R6 warm keep value", rd_data, 32'h08);
    check("R8 flush on warm", {31'h0, flush_req}, 32'h1);
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    check("R8 flush lasts one cycle", {31'h0, flush_req}, 32'h0);
    wr(32'h0D);
    cap_keep_warm = 1'b0;
    step(1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    check("R6 warm clear value", rd_data, 32'h00);
    check("R8 flush on warm clear", {31'h0, flush_req}, 32'h1);
    cap_keep_warm = 1'b1;

    // R7 interrupt event
    wr(32'hF5);
    check("R2 full write", rd_data, 32'hF5);
    step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0);
    check("R7 interrupt value", rd_data, 32'hF4);
    check("R8 flush on interrupt", {31'h0, flush_req}, 32'h1);
    check("R9 gen off after interrupt", {31'h0, gen_en}, 32'h0);

    // R10 coincident events
    step(1'b1, 32'hF5, 1'b0, 1'b1, 1'b0);
    check("R10 interrupt beats write", rd_data, 32'hF4);
    check("R10 dropped write no fault", {31'h0, wr_fault}, 32'h0);
    step(1'b1, 32'h100, 1'b0, 1'b1, 1'b0);
    check("R10 dropped illegal write no fault", {31'h0, wr_fault}, 32'h0);
    check("R10 value after dropped illegal", rd_data, 32'hF4);
    step(1'b1, 32'h01, 1'b1, 1'b1, 1'b0);
    check("R10 warm beats interrupt and write", rd_data, 32'hF4);
    wr(32'hF5);
    step(1'b1, 32'h03, 1'b1, 1'b1, 1'b1);
    check("R1 R10 cold beats all", rd_data, 32'h00);
    check("R1 R8 no flush on cold", {31'h0, flush_req}, 32'h0);
    check("R1 no fault on cold", {31'h0, wr_fault}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule